// File: doc/BRIEF.md
# Bit-Alias Address Bridge

This bridge sits between a single 32-bit bus master and a word-addressed memory. A window of the master's address space is set aside as a bit alias: every 32-bit word in that window stands for exactly one bit of a smaller backing region in the memory. The alias window is 32 times the size of the backing region.

A read from an alias word returns the state of its one bit, zero-extended to 32 bits. A write to an alias word becomes an indivisible read-modify-write of that bit in memory. The bridge reads the backing word, changes only the addressed bit, and writes the word back. No other memory access can fall between the read and the write-back. Software can therefore flip a single flag with one store, without its own load/modify/store sequence.

Addresses outside the alias window go to the memory unchanged, as one access each. The master is held with its ready signal low while a memory read is outstanding.

Top module: `bitband_bridge`

## Requirements
- R1: A master write outside the alias window completes in the cycle it is presented (ready high), as exactly one memory write to word address addr[31:2] carrying the master's data unchanged.
- R2: A master read outside the alias window issues one memory read to word address addr[31:2]. Ready is high in the following cycle, with the read data returned unchanged.
- R3: An address A with ALIAS_BASE <= A < ALIAS_BASE + 32*REGION_BYTES maps to bit index i = (A - ALIAS_BASE) >> 2. The byte offset is i >> 3 and the bit number within that byte is i & 7. The backing word address is REGION_BASE[31:2] + (i >> 5), and the bit position inside the 32-bit word is i & 31 (little-endian byte order).
- R4: An alias read returns 32'h0000_0001 when the addressed bit is set and 32'h0000_0000 when it is clear. It uses one memory read, with ready high in the second cycle.
- R5: An alias write copies bit 0 of the write data into the addressed bit (1 sets it, 0 clears it). Bits 31:1 of the write data are ignored, and every other bit of the backing word keeps its value.
- R6: An alias write uses exactly two memory accesses in consecutive cycles: a read and then a write to the same word address. Ready is low during the read cycle and high during the write cycle.
- R7: While reset is active, and in any idle cycle without a master request, the bridge drives no memory request and keeps ready low.
- R8: The last alias word (ALIAS_BASE + 32*REGION_BYTES - 4) maps to bit 31 of the last backing word. The addresses just above the window and just below it are forwarded as pass-through accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_req_i | input | 1 | Master request, held until ready |
| m_we_i | input | 1 | Master write enable |
| m_addr_i | input | 32 | Master byte address |
| m_wdata_i | input | 32 | Master write data |
| m_ready_o | output | 1 | Access completes in this cycle |
| m_rdata_o | output | 32 | Read data, valid with ready |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 30 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after a read strobe |

## Verification
The assertions assume that the master keeps its request, direction, address and data steady until it sees ready. They also assume that the memory always accepts an access and presents read data in exactly the next cycle. The single-bit-change check on the write-back compares against this data. The bench drives each request at a falling edge and holds it until ready is seen. It releases the request only at the falling edge after completion. Its memory model registers read data on the same rising edge that takes the strobe, which gives exactly that one-cycle latency.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int unsigned DW  = 32;
  localparam int unsigned WAW = 30;
  localparam int unsigned PW  = $clog2(DW);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PT_RD = 2'd1,
    ST_AL_RD = 2'd2,
    ST_RMW   = 2'd3
  } bb_state_e;

  typedef struct packed {
    logic           hit;
    logic [WAW-1:0] waddr;
    logic [PW-1:0]  pos;
  } bb_dec_t;
endpackage

// File: rtl/bb_addr_decode.sv
module bb_addr_decode
  import bb_pkg::*;
#(
  parameter logic [31:0] ALIAS_BASE   = 32'h2200_0000,
  parameter logic [31:0] REGION_BASE  = 32'h2000_0000,
  parameter int unsigned REGION_BYTES = 1 << 20
) (
  input  logic [31:0] addr_i,
  output bb_dec_t     dec_o
);
  localparam int unsigned REGION_AW   = $clog2(REGION_BYTES);
  localparam int unsigned SPAN_AW     = REGION_AW + 5;
  localparam int unsigned BIT_IDX_W   = REGION_AW + 3;
  localparam int unsigned WORD_OFF_W  = REGION_AW - 2;
  localparam logic [32:0] ALIAS_BYTES = 33'(REGION_BYTES) << 5;

  logic [32:0]           diff;
  logic [BIT_IDX_W-1:0]  bit_idx;
  logic [WORD_OFF_W-1:0] word_off;

  assign diff     = {1'b0, addr_i} - {1'b0, ALIAS_BASE};
  assign bit_idx  = diff[SPAN_AW-1:2];
  assign word_off = bit_idx[BIT_IDX_W-1:5];

  assign dec_o.hit   = !diff[32] && (diff < ALIAS_BYTES);
  assign dec_o.waddr = REGION_BASE[31:2] + WAW'(word_off);
  assign dec_o.pos   = bit_idx[PW-1:0];
endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane
  import bb_pkg::*;
(
  input  logic [DW-1:0] word_i,
  input  logic [PW-1:0] pos_i,
  input  logic          val_i,
  output logic [DW-1:0] merged_o,
  output logic          bit_o
);
  logic [DW-1:0] sel;

  for (genvar i = 0; i < DW; i++) begin : g_lane
    assign sel[i]      = (pos_i == PW'(i));
    assign merged_o[i] = sel[i] ? val_i : word_i[i];
  end

  assign bit_o = |(sel & word_i);
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           m_req_i,
  input  logic           m_we_i,
  input  logic [31:0]    m_addr_i,
  input  logic [DW-1:0]  m_wdata_i,
  input  bb_dec_t        dec_i,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic [DW-1:0]  merged_i,
  input  logic           ext_bit_i,
  output logic           m_ready_o,
  output logic [DW-1:0]  m_rdata_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [WAW-1:0] mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic [PW-1:0]  pos_o,
  output logic           val_o,
  output bb_state_e      st_o
);
  bb_state_e      st_q, st_d;
  logic [WAW-1:0] waddr_q;
  logic [PW-1:0]  pos_q;
  logic           val_q;
  logic           take;

  assign take = (st_q == ST_IDLE) && m_req_i && dec_i.hit;

  always_comb begin
    st_d        = st_q;
    m_ready_o   = 1'b0;
    m_rdata_o   = mem_rdata_i;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = waddr_q;
    mem_wdata_o = m_wdata_i;
    unique case (st_q)
      ST_IDLE: begin
        if (m_req_i) begin
          mem_req_o = 1'b1;
          if (!dec_i.hit) begin
            mem_we_o   = m_we_i;
            mem_addr_o = m_addr_i[31:2];
            if (m_we_i) m_ready_o = 1'b1;
            else        st_d      = ST_PT_RD;
          end else begin
            mem_addr_o = dec_i.waddr;
            st_d       = m_we_i ? ST_RMW : ST_AL_RD;
          end
        end
      end
      ST_PT_RD: begin
        m_ready_o = 1'b1;
        st_d      = ST_IDLE;
      end
      ST_AL_RD: begin
        m_ready_o = 1'b1;
        m_rdata_o = {{(DW-1){1'b0}}, ext_bit_i};
        st_d      = ST_IDLE;
      end
      ST_RMW: begin
        // write-back follows the read with no gap
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = merged_i;
        m_ready_o   = 1'b1;
        st_d        = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      waddr_q <= '0;
      pos_q   <= '0;
      val_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (take) begin
        waddr_q <= dec_i.waddr;
        pos_q   <= dec_i.pos;
        val_q   <= m_wdata_i[0];
      end
    end
  end

  assign pos_o = pos_q;
  assign val_o = val_q;
  assign st_o  = st_q;
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter logic [31:0] ALIAS_BASE   = 32'h2200_0000,
  parameter logic [31:0] REGION_BASE  = 32'h2000_0000,
  parameter int unsigned REGION_BYTES = 1 << 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        m_req_i,
  input  logic        m_we_i,
  input  logic [31:0] m_addr_i,
  input  logic [31:0] m_wdata_i,
  output logic        m_ready_o,
  output logic [31:0] m_rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [29:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i
);
  bb_dec_t       dec;
  bb_state_e     st;
  logic [PW-1:0] pos;
  logic          val;
  logic [DW-1:0] merged;
  logic          ext_bit;

  bb_addr_decode #(
    .ALIAS_BASE  (ALIAS_BASE),
    .REGION_BASE (REGION_BASE),
    .REGION_BYTES(REGION_BYTES)
  ) u_dec (
    .addr_i(m_addr_i),
    .dec_o (dec)
  );

  bb_bit_lane u_lane (
    .word_i  (mem_rdata_i),
    .pos_i   (pos),
    .val_i   (val),
    .merged_o(merged),
    .bit_o   (ext_bit)
  );

  bb_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .m_req_i    (m_req_i),
    .m_we_i     (m_we_i),
    .m_addr_i   (m_addr_i),
    .m_wdata_i  (m_wdata_i),
    .dec_i      (dec),
    .mem_rdata_i(mem_rdata_i),
    .merged_i   (merged),
    .ext_bit_i  (ext_bit),
    .m_ready_o  (m_ready_o),
    .m_rdata_o  (m_rdata_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .pos_o      (pos),
    .val_o      (val),
    .st_o       (st)
  );
endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk
  import bb_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        m_req_i,
  input logic        m_we_i,
  input logic [31:0] m_addr_i,
  input logic [31:0] m_wdata_i,
  input logic        m_ready_o,
  input logic [31:0] m_rdata_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [29:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic [31:0] mem_rdata_i,
  input bb_state_e   st_i
);
  p_fwd_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && m_req_i && m_we_i && m_ready_o) |->
      (mem_req_o && mem_we_o && mem_wdata_o == m_wdata_i && mem_addr_o == m_addr_i[31:2]));

  p_fwd_read_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PT_RD) |-> (m_ready_o && m_rdata_o == mem_rdata_i && !mem_req_o));

  p_alias_rd_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_AL_RD) |-> (m_ready_o && m_rdata_o[31:1] == 31'd0 && !mem_req_o));

  p_one_bit_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RMW) |-> ($countones(mem_wdata_o ^ mem_rdata_i) <= 1));

  p_rmw_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RMW) |->
      (mem_req_o && mem_we_o && $past(mem_req_o && !mem_we_o) && mem_addr_o == $past(mem_addr_o)));

  p_wait_on_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && mem_req_o && !mem_we_o) |-> !m_ready_o);

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && !m_req_i) |-> (!mem_req_o && !m_ready_o));
endmodule

bind bitband_bridge bitband_bridge_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .m_req_i    (m_req_i),
  .m_we_i     (m_we_i),
  .m_addr_i   (m_addr_i),
  .m_wdata_i  (m_wdata_i),
  .m_ready_o  (m_ready_o),
  .m_rdata_o  (m_rdata_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_rdata_i(mem_rdata_i),
  .st_i       (st)
);

// File: tb/bitband_bridge_tb_top.sv
module bitband_bridge_tb_top;
  localparam logic [31:0] AB     = 32'h2200_0000;
  localparam logic [31:0] RB     = 32'h2000_0000;
  localparam int          RBYTES = 256;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        m_req = 1'b0, m_we = 1'b0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic        m_ready_o, mem_req_o, mem_we_o;
  logic [31:0] m_rdata_o, mem_wdata_o, mem_rd_q;
  logic [29:0] mem_addr_o;

  int n_run = 0, n_fail = 0;
  int acc_cnt = 0;
  logic [29:0] first_addr, last_addr;
  logic        first_we, last_we;
  logic [31:0] mem [64];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  bitband_bridge #(.ALIAS_BASE(AB), .REGION_BASE(RB), .REGION_BYTES(RBYTES)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .m_req_i(m_req), .m_we_i(m_we), .m_addr_i(m_addr),
    .m_wdata_i(m_wdata), .m_ready_o(m_ready_o), .m_rdata_o(m_rdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rd_q)
  );

  // memory model: read data one cycle after the strobe
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o[5:0]] <= mem_wdata_o;
      else          mem_rd_q <= mem[mem_addr_o[5:0]];
      if (acc_cnt == 0) begin
        first_addr = mem_addr_o;
        first_we   = mem_we_o;
      end
      last_addr = mem_addr_o;
      last_we   = mem_we_o;
      acc_cnt   = acc_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] al(input int byte_i, input int bit_i);
    return AB + 32'(byte_i * 32) + 32'(bit_i * 4);
  endfunction

  task automatic bus(input logic we, input logic [31:0] addr, input logic [31:0] wdata,
                     output logic [31:0] rdata, output int cycles);
    @(negedge clk);
    m_req = 1'b1; m_we = we; m_addr = addr; m_wdata = wdata;
    acc_cnt = 0; cycles = 0; rdata = 'x;
    while (cycles < 20) begin
      cycles++;
      #2;
      if (m_ready_o) begin
        rdata = m_rdata_o;
        @(negedge clk);
        m_req = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R7 ready in reset", 32'(m_ready_o), 32'd0);
    chk("R7 mem_req in reset", 32'(mem_req_o), 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 ready idle", 32'(m_ready_o), 32'd0);
    chk("R7 mem_req idle", 32'(mem_req_o), 32'd0);
  endtask

  task automatic t_passthru();
    logic [31:0] rd; int cyc;
    bus(1'b1, 32'h2000_0010, 32'hA5C3_0F96, rd, cyc);
    chk("R1 write cycles", 32'(cyc), 32'd1);
    chk("R1 write accesses", 32'(acc_cnt), 32'd1);
    chk("R1 write addr", 32'(last_addr), 32'h0800_0004);
    chk("R1 write kind", 32'(last_we), 32'd1);
    bus(1'b0, 32'h2000_0010, 32'h0, rd, cyc);
    chk("R2 read data", rd, 32'hA5C3_0F96);
    chk("R2 read cycles", 32'(cyc), 32'd2);
    chk("R2 read accesses", 32'(acc_cnt), 32'd1);
  endtask

  task automatic t_alias_read();
    logic [31:0] rd; int cyc;
    bus(1'b1, 32'h2000_000C, 32'h0000_8001, rd, cyc);
    bus(1'b0, al(12, 0), 32'h0, rd, cyc);
    chk("R4 alias read set", rd, 32'h1);
    chk("R4 alias read cycles", 32'(cyc), 32'd2);
    chk("R3 alias read word", 32'(last_addr), 32'h0800_0003);
    chk("R4 alias read accesses", 32'(acc_cnt), 32'd1);
    bus(1'b0, al(13, 7), 32'h0, rd, cyc);
    chk("R3 byte 13 bit 7", rd, 32'h1);
    bus(1'b0, al(12, 1), 32'h0, rd, cyc);
    chk("R4 alias read clear", rd, 32'h0);
  endtask

  task automatic t_alias_sweep();
    logic [31:0] rd; int cyc;
    logic [31:0] pat = 32'h3C5A_96E1;
    bus(1'b1, 32'h2000_001C, pat, rd, cyc);
    for (int b = 0; b < 32; b++) begin
      bus(1'b0, al(28 + b / 8, b % 8), 32'h0, rd, cyc);
      chk($sformatf("R3 sweep bit %0d", b), rd, {31'd0, pat[b]});
    end
  endtask

  task automatic t_alias_write();
    logic [31:0] rd; int cyc;
    bus(1'b1, 32'h2000_0008, 32'h1234_5678, rd, cyc);
    bus(1'b1, al(10, 3), 32'hFFFF_FFFF, rd, cyc);
    chk("R6 rmw cycles", 32'(cyc), 32'd2);
    chk("R6 rmw accesses", 32'(acc_cnt), 32'd2);
    chk("R6 rmw read first", 32'(first_we), 32'd0);
    chk("R6 rmw write last", 32'(last_we), 32'd1);
    chk("R6 rmw same word", 32'(last_addr), 32'(first_addr));
    chk("R3 rmw word", 32'(first_addr), 32'h0800_0002);
    bus(1'b0, 32'h2000_0008, 32'h0, rd, cyc);
    chk("R5 set bit 19", rd, 32'h123C_5678);
    bus(1'b1, al(10, 3), 32'hFFFF_FFFE, rd, cyc);
    bus(1'b0, 32'h2000_0008, 32'h0, rd, cyc);
    chk("R5 clear ignores upper data", rd, 32'h1234_5678);
    bus(1'b1, al(8, 0), 32'h0000_0001, rd, cyc);
    bus(1'b0, 32'h2000_0008, 32'h0, rd, cyc);
    chk("R5 set bit 0", rd, 32'h1234_5679);
  endtask

  task automatic t_bounds();
    logic [31:0] rd; int cyc;
    bus(1'b1, AB + 32'h1FFC, 32'h1, rd, cyc);
    chk("R8 last alias word", 32'(last_addr), 32'h0800_003F);
    bus(1'b0, 32'h2000_00FC, 32'h0, rd, cyc);
    chk("R8 last bit set", rd, 32'h8000_0000);
    bus(1'b0, AB + 32'h1FFC, 32'h0, rd, cyc);
    chk("R8 last alias read", rd, 32'h1);
    bus(1'b1, AB + 32'h2000, 32'hDEAD_BEEF, rd, cyc);
    chk("R8 above window cycles", 32'(cyc), 32'd1);
    chk("R8 above window addr", 32'(last_addr), 32'h0880_0800);
    chk("R8 above window data", mem[0], 32'hDEAD_BEEF);
    bus(1'b1, AB - 32'd4, 32'h0BAD_F00D, rd, cyc);
    chk("R8 below window cycles", 32'(cyc), 32'd1);
    chk("R8 below window addr", 32'(last_addr), 32'h087F_FFFF);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem_rd_q = '0;
    t_reset();
    t_passthru();
    t_alias_read();
    t_alias_sweep();
    t_alias_write();
    t_bounds();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule